// File: doc/BRIEF.md
# Linked-Descriptor Scatter-Gather DMA Engine

This block is a bus-master transfer engine that moves bytes between one device port and memory. It does not take a single address/length pair. It walks a chain of descriptors held in memory, and the chain can scatter one device stream into several unrelated buffers or gather it from them. Software places the descriptors in memory, gives the engine the address of the first one and pulses `start`. From then on the engine fetches each descriptor, runs the byte loop, follows the next pointer and raises a single interrupt when the chain ends or when something fails. Software reads busy, done, error, the current descriptor address and the remaining count from the status outputs, and pulses `clr_done` to drop the interrupt.

Each descriptor is four consecutive 32-bit little-endian words at byte offsets 0, 4, 8 and 12 from its base:
- **Word 0 (control):** bit 0 is the direction. 1 moves bytes from the device to memory; 0 moves bytes from memory to the device.
- **Word 1:** the buffer address.
- **Word 2:** the byte count, in its low `CW` bits.
- **Word 3:** the next-descriptor address. A next address of zero ends the chain.

The engine arbitrates for the bus before every memory access. It holds `bus_req`, together with a stable address and stable controls, until a cycle in which `bus_gnt` and `mem_ack` are both high. The device side uses a `dev_req`/`dev_ack` handshake with the same rule.

The controller is a state machine with these states:
- **IDLE:** waiting for `start`.
- **FETCH:** four word reads of the descriptor.
- **EXEC:** decides what the descriptor needs.
- **MEM_RD:** reads one byte from memory.
- **DEV_WR:** hands the byte to the device.
- **DEV_RD:** takes one byte from the device.
- **MEM_WR:** stores the byte in memory.
- **NEXT:** follows the chain or ends it.

The transitions between the states are these:
- **IDLE → FETCH:** when `start` is seen.
- **FETCH → FETCH:** after each accepted word other than the last.
- **FETCH → EXEC:** after the fourth word.
- **EXEC → NEXT:** when the count is zero.
- **EXEC → DEV_RD:** for the device-to-memory direction.
- **EXEC → MEM_RD:** for the memory-to-device direction.
- **MEM_RD → DEV_WR:** once the byte has been read.
- **DEV_WR → MEM_RD:** after a byte that is not the last one.
- **DEV_WR → NEXT:** after the last byte.
- **DEV_RD → MEM_WR:** once the device has supplied the byte.
- **MEM_WR → DEV_RD:** after a byte that is not the last one.
- **MEM_WR → NEXT:** after the last byte.
- **NEXT → FETCH:** when the next address is non-zero.
- **NEXT → IDLE:** when the next address is zero; this sets done.
- **Any active state → IDLE:** on a bus error or a device error; this sets error.

Top module: `chain_dma`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `err` and `irq` are 0, and neither `bus_req` nor `dev_req` is asserted.
- R2: `start` loads `start_ptr` as the current descriptor address and the engine reads four words at that address plus 0, 4, 8 and 12. Word 0 bit 0 is the direction (1 = device to memory). Word 1 is the buffer address, word 2 the byte count and word 3 the next pointer. A pending `bus_req` keeps its address and write flag stable until `bus_gnt` and `mem_ack` are both high.
- R3: With direction 0, each byte is read from memory at the current address (`mem_byte`=1, low data byte) and then offered to the device with `dev_wr`=1. After each byte the address increments by one and the count decrements by one.
- R4: With direction 1, each byte is taken from the device (`dev_wr`=0) and written to memory at the current address, in the low byte of `mem_wdata` with `mem_we`=1 and `mem_byte`=1.
- R5: When a descriptor's count reaches zero, a non-zero next pointer makes the engine fetch that descriptor, so buffers in a chain need not be contiguous.
- R6: A descriptor with a count of zero causes no memory byte access and no device access before the engine moves on.
- R7: A next pointer of zero ends the chain. `done` and `irq` go to 1 and `busy` to 0, and `irq` rises only once for the whole chain.
- R8: A bus error (`mem_err` on an accepted access), on either a descriptor fetch or a data access, aborts the chain. `err` and `irq` go to 1 and `done` stays 0. `cur_desc` keeps the failing descriptor's address and `rem_count` the bytes not yet moved.
- R9: A device error (`dev_err` with `dev_ack`) aborts the chain in the same way, and the failed byte is not counted as moved.
- R10: A `clr_done` pulse clears `done`, `err` and `irq`. While no clear or start is seen, `irq` stays set.
- R11: A `start` pulse while `busy` is 1 is ignored, and the running chain completes unchanged.
- R12: `bus_req` and `dev_req` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_ptr | input | AW | Address of the first descriptor |
| clr_done | input | 1 | Clears done, err and irq |
| busy | output | 1 | A chain is in progress |
| done | output | 1 | The chain finished normally |
| err | output | 1 | The chain was aborted by an error |
| irq | output | 1 | Interrupt request (done or err) |
| cur_desc | output | AW | Address of the descriptor being processed |
| rem_count | output | CW | Bytes left in the current descriptor |
| bus_req | output | 1 | Bus request with an access pending |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Memory byte address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | 1 = byte access, 0 = 32-bit word access |
| mem_wdata | output | DW | Write data (byte in bits 7:0) |
| mem_rdata | input | DW | Read data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response together with mem_ack |
| dev_req | output | 1 | Device transfer pending |
| dev_wr | output | 1 | 1 = byte to the device, 0 = byte from the device |
| dev_wdata | output | 8 | Byte to the device |
| dev_rdata | input | 8 | Byte from the device |
| dev_ack | input | 1 | Device handshake completes this cycle |
| dev_err | input | 1 | Device error together with dev_ack |

## Verification
Every bus or device handshake completes on the first rising edge at which the request meets its acknowledge. The bench raises each acknowledge on a falling edge, and in the same half-cycle it applies any memory write and checks the device byte against the scoreboard queue. Each expected item is therefore compared exactly when the design commits it, regardless of the bench's grant and acknowledge stalls. The status flags, `cur_desc` and `rem_count` change on the edge that returns the engine to IDLE, so status is read on the falling edge after `busy` is seen low. The effect of a `clr_done` pulse is read one falling edge after the pulse.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_MEM_RD,
        ST_DEV_WR,
        ST_DEV_RD,
        ST_MEM_WR,
        ST_NEXT
    } dma_state_e;

    localparam int DESC_WORDS = 4;
endpackage

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       bus_ok,
    input  logic       bus_fail,
    input  logic       dev_ok,
    input  logic       dev_fail,
    input  logic       last_word,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    input  logic       dir_in,
    input  logic       next_zero,
    output dma_state_e state_q,
    output logic       ld_start,
    output logic       take_word,
    output logic       step,
    output logic       latch_byte,
    output logic       ld_next,
    output logic       set_done,
    output logic       set_err
);
    dma_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        ld_start   = 1'b0;
        take_word  = 1'b0;
        step       = 1'b0;
        latch_byte = 1'b0;
        ld_next    = 1'b0;
        set_done   = 1'b0;
        set_err    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ld_start = 1'b1;
                    state_d  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (bus_fail) begin
                    set_err = 1'b1;
                    state_d = ST_IDLE;
                end else if (bus_ok) begin
                    take_word = 1'b1;
                    if (last_word) state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (cnt_zero)    state_d = ST_NEXT;
                else if (dir_in) state_d = ST_DEV_RD;
                else             state_d = ST_MEM_RD;
            end
            ST_MEM_RD: begin
                if (bus_fail) begin
                    set_err = 1'b1;
                    state_d = ST_IDLE;
                end else if (bus_ok) begin
                    latch_byte = 1'b1;
                    state_d    = ST_DEV_WR;
                end
            end
            ST_DEV_WR: begin
                if (dev_fail) begin
                    set_err = 1'b1;
                    state_d = ST_IDLE;
                end else if (dev_ok) begin
                    step    = 1'b1;
                    state_d = cnt_one ? ST_NEXT : ST_MEM_RD;
                end
            end
            ST_DEV_RD: begin
                if (dev_fail) begin
                    set_err = 1'b1;
                    state_d = ST_IDLE;
                end else if (dev_ok) begin
                    latch_byte = 1'b1;
                    state_d    = ST_MEM_WR;
                end
            end
            ST_MEM_WR: begin
                if (bus_fail) begin
                    set_err = 1'b1;
                    state_d = ST_IDLE;
                end else if (bus_ok) begin
                    step    = 1'b1;
                    state_d = cnt_one ? ST_NEXT : ST_DEV_RD;
                end
            end
            ST_NEXT: begin
                if (next_zero) begin
                    set_done = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    ld_next = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R6: a zero-count descriptor goes straight on to the chaining step
    a_r6_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && cnt_zero) |=> (state_q == ST_NEXT));
endmodule

// File: rtl/dma_desc_path.sv
module dma_desc_path #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_ptr,
    input  logic [DW-1:0] mem_rdata,
    input  logic [7:0]    dev_rdata,
    input  logic          ld_start,
    input  logic          take_word,
    input  logic          step,
    input  logic          latch_byte,
    input  logic          ld_next,
    output logic [AW-1:0] cur_q,
    output logic [AW-1:0] desc_addr,
    output logic [AW-1:0] buf_addr,
    output logic [CW-1:0] cnt_q,
    output logic [7:0]    byte_q,
    output logic          dir_q,
    output logic          last_word,
    output logic          cnt_zero,
    output logic          cnt_one,
    output logic          next_zero
);
    localparam int IW = $clog2(dma_pkg::DESC_WORDS);

    logic [IW-1:0] widx_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] next_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            widx_q <= '0;
            dir_q  <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            next_q <= '0;
            byte_q <= '0;
        end else begin
            if (ld_start) begin
                cur_q  <= start_ptr;
                widx_q <= '0;
            end else if (ld_next) begin
                cur_q  <= next_q;
                widx_q <= '0;
            end else if (take_word) begin
                widx_q <= widx_q + 1'b1;
                case (widx_q)
                    2'd0:    dir_q  <= mem_rdata[0];
                    2'd1:    addr_q <= AW'(mem_rdata);
                    2'd2:    cnt_q  <= mem_rdata[CW-1:0];
                    default: next_q <= AW'(mem_rdata);
                endcase
            end
            if (latch_byte) byte_q <= dir_q ? dev_rdata : mem_rdata[7:0];
            if (step) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign desc_addr = cur_q + (AW'(widx_q) << 2);
    assign buf_addr  = addr_q;
    assign last_word = (widx_q == IW'(dma_pkg::DESC_WORDS - 1));
    assign cnt_zero  = (cnt_q == '0);
    assign cnt_one   = (cnt_q == CW'(1));
    assign next_zero = (next_q == '0);

    // R3: one completed byte moves the address up and the count down by one
    a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == $past(addr_q) + 1'b1) && (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dma_status.sv
module dma_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_start,
    input  logic set_done,
    input  logic set_err,
    input  logic clr_done,
    output logic done_q,
    output logic err_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_done || ld_start) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (set_done) done_q <= 1'b1;
            if (set_err)  err_q  <= 1'b1;
        end
    end

    assign irq = done_q | err_q;

    // R10: the interrupt stays up until it is cleared or a new chain starts
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_done && !ld_start) |=> irq);

    // R7 / R8: a chain ends either normally or with an error, never both
    a_r7_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));
endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_ptr,
    input  logic          clr_done,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          irq,
    output logic [AW-1:0] cur_desc,
    output logic [CW-1:0] rem_count,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_byte,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          dev_req,
    output logic          dev_wr,
    output logic [7:0]    dev_wdata,
    input  logic [7:0]    dev_rdata,
    input  logic          dev_ack,
    input  logic          dev_err
);
    dma_state_e    state_q;
    logic          ld_start, take_word, step, latch_byte, ld_next, set_done, set_err;
    logic          bus_ok, bus_fail, dev_ok, dev_fail;
    logic          last_word, cnt_zero, cnt_one, dir_q, next_zero;
    logic [AW-1:0] desc_addr, buf_addr;
    logic [7:0]    byte_q;

    assign bus_req   = (state_q == ST_FETCH) || (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
    assign mem_we    = (state_q == ST_MEM_WR);
    assign mem_byte  = (state_q != ST_FETCH);
    assign mem_addr  = (state_q == ST_FETCH) ? desc_addr : buf_addr;
    assign mem_wdata = DW'(byte_q);
    assign dev_req   = (state_q == ST_DEV_WR) || (state_q == ST_DEV_RD);
    assign dev_wr    = (state_q == ST_DEV_WR);
    assign dev_wdata = byte_q;
    assign busy      = (state_q != ST_IDLE);
    assign rem_count = cnt_q_w;

    logic [CW-1:0] cnt_q_w;

    assign bus_ok   = bus_req && bus_gnt && mem_ack && !mem_err;
    assign bus_fail = bus_req && bus_gnt && mem_ack && mem_err;
    assign dev_ok   = dev_req && dev_ack && !dev_err;
    assign dev_fail = dev_req && dev_ack && dev_err;

    dma_chain_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .bus_ok     (bus_ok),
        .bus_fail   (bus_fail),
        .dev_ok     (dev_ok),
        .dev_fail   (dev_fail),
        .last_word  (last_word),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .dir_in     (dir_q),
        .next_zero  (next_zero),
        .state_q    (state_q),
        .ld_start   (ld_start),
        .take_word  (take_word),
        .step       (step),
        .latch_byte (latch_byte),
        .ld_next    (ld_next),
        .set_done   (set_done),
        .set_err    (set_err)
    );

    dma_desc_path #(.AW(AW), .DW(DW), .CW(CW)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ptr  (start_ptr),
        .mem_rdata  (mem_rdata),
        .dev_rdata  (dev_rdata),
        .ld_start   (ld_start),
        .take_word  (take_word),
        .step       (step),
        .latch_byte (latch_byte),
        .ld_next    (ld_next),
        .cur_q      (cur_desc),
        .desc_addr  (desc_addr),
        .buf_addr   (buf_addr),
        .cnt_q      (cnt_q_w),
        .byte_q     (byte_q),
        .dir_q      (dir_q),
        .last_word  (last_word),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .next_zero  (next_zero)
    );

    dma_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_start (ld_start),
        .set_done (set_done),
        .set_err  (set_err),
        .clr_done (clr_done),
        .done_q   (done),
        .err_q    (err),
        .irq      (irq)
    );

    // R2: a waiting bus request keeps its address and direction
    a_r2_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(bus_gnt && mem_ack)) |=> (bus_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: never both sides at once
    a_r12_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req, dev_req}));

    // R1: an idle engine issues no requests
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !dev_req));

    // R8: an abort leaves the remaining count untouched
    a_r8_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $stable(rem_count));
endmodule

// File: tb/tb_chain_dma.sv
module tb_chain_dma;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_ptr = '0;
    logic          clr_done = 1'b0;
    logic          busy, done, err, irq;
    logic [AW-1:0] cur_desc;
    logic [CW-1:0] rem_count;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_byte;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic          dev_req, dev_wr;
    logic [7:0]    dev_wdata;
    logic [7:0]    dev_rdata = 8'h00;
    logic          dev_ack = 1'b0;
    logic          dev_err = 1'b0;

    always #5 clk = ~clk;

    chain_dma #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

    logic [7:0]  mem [0:2047];
    logic [10:0] ma;
    assign ma = mem_addr[10:0];
    assign mem_rdata = {mem[ma + 11'd3], mem[ma + 11'd2], mem[ma + 11'd1], mem[ma]};

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0]  exp_dev [$];
    logic [18:0] exp_mem [$];   // {addr[10:0], data}
    int  rd_bytes, rd_words, dev_seen, dev_rd_seen, irq_rises;
    bit  err_en = 0;
    logic [10:0] err_addr = '0;
    bit  dev_err_en = 0;
    int  dev_err_idx = 0;
    logic irq_prev = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // bus / device models and scoreboard monitor, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && irq && !irq_prev) irq_rises++;
        irq_prev = irq;
        if (bus_req && (cyc % 3 != 2)) begin
            bus_gnt = 1'b1;
            mem_ack = 1'b1;
            mem_err = err_en && (ma == err_addr);
            if (!mem_err) begin
                if (!mem_byte) rd_words++;
                else if (!mem_we) rd_bytes++;
                else begin
                    mem[ma] = mem_wdata[7:0];
                    checks++;
                    if (exp_mem.size() == 0) begin
                        errors++;
                        $display("FAIL R4 actual=%0h expected=none", {ma, mem_wdata[7:0]});
                    end else begin
                        logic [18:0] e;
                        e = exp_mem.pop_front();
                        if (e !== {ma, mem_wdata[7:0]}) begin
                            errors++;
                            $display("FAIL R4 actual=%0h expected=%0h", {ma, mem_wdata[7:0]}, e);
                        end
                    end
                end
            end
        end else begin
            bus_gnt = 1'b0;
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
        if (dev_req && (cyc % 2 == 0)) begin
            dev_ack   = 1'b1;
            dev_err   = dev_err_en && (dev_seen == dev_err_idx);
            dev_rdata = 8'hA0 + 8'(dev_rd_seen);
            if (!dev_err) begin
                if (dev_wr) begin
                    checks++;
                    if (exp_dev.size() == 0) begin
                        errors++;
                        $display("FAIL R3 actual=%0h expected=none", dev_wdata);
                    end else begin
                        logic [7:0] e;
                        e = exp_dev.pop_front();
                        if (e !== dev_wdata) begin
                            errors++;
                            $display("FAIL R3 actual=%0h expected=%0h", dev_wdata, e);
                        end
                    end
                end else dev_rd_seen++;
            end
            dev_seen++;
        end else begin
            dev_ack = 1'b0;
            dev_err = 1'b0;
        end
    end

    task automatic put_word(input int a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[11'(a + i)] = v[8*i +: 8];
    endtask

    task automatic put_desc(input int a, input bit dir, input int buf_a, input int cnt, input int nxt);
        put_word(a,      {31'd0, dir});
        put_word(a + 4,  32'(buf_a));
        put_word(a + 8,  32'(cnt));
        put_word(a + 12, 32'(nxt));
    endtask

    task automatic clear_stats();
        rd_bytes = 0; rd_words = 0; dev_seen = 0; dev_rd_seen = 0; irq_rises = 0;
    endtask

    task automatic pulse_start(input int p);
        @(negedge clk); start = 1'b1; start_ptr = 32'(p);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clr_done = 1'b1;
        @(negedge clk); clr_done = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (busy) begin
            checks++; errors++;
            $display("FAIL %s watchdog actual=busy expected=idle", tag);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 flags", {done, err, irq}, 0);
        chk("R1 requests", {bus_req, dev_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Chain: A mem->dev 3 bytes, B zero count, C dev->mem 2 bytes, D mem->dev 1 byte
        put_desc(32'h100, 0, 32'h200, 3, 32'h140);
        put_desc(32'h140, 0, 32'h600, 0, 32'h180);
        put_desc(32'h180, 1, 32'h300, 2, 32'h1C0);
        put_desc(32'h1C0, 0, 32'h250, 1, 0);
        mem[11'h200] = 8'h11; mem[11'h201] = 8'h22; mem[11'h202] = 8'h33; mem[11'h250] = 8'h44;
        clear_stats();
        exp_dev.push_back(8'h11); exp_dev.push_back(8'h22); exp_dev.push_back(8'h33);
        exp_dev.push_back(8'h44);
        exp_mem.push_back({11'h300, 8'hA0}); exp_mem.push_back({11'h301, 8'hA1});
        pulse_start(32'h100);
        repeat (6) @(negedge clk);
        chk("R11 busy during chain", busy, 1);
        pulse_start(32'h400);    // R11: must be ignored
        wait_idle("R7");
        chk("R7 done/err", {done, err}, 2'b10);
        chk("R7 irq", irq, 1);
        chk("R7 single irq rise", irq_rises, 1);
        chk("R5 final descriptor", cur_desc, 32'h1C0);
        chk("R11 ignored start left chain intact", exp_dev.size() + exp_mem.size(), 0);
        chk("R2 descriptor words fetched", rd_words, 16);
        chk("R6 zero count made no byte reads", rd_bytes, 4);
        chk("R6 device handshakes", dev_seen, 6);
        chk("R4 scattered bytes in memory", {mem[11'h300], mem[11'h301]}, 16'hA0A1);
        chk("R3 count exhausted", rem_count, 0);

        repeat (3) @(negedge clk);
        chk("R10 irq held", irq, 1);
        pulse_clear();
        chk("R10 cleared", {done, err, irq}, 0);

        // R8: bus error on the third data byte
        put_desc(32'h400, 0, 32'h500, 4, 0);
        mem[11'h500] = 8'h01; mem[11'h501] = 8'h02; mem[11'h502] = 8'h03; mem[11'h503] = 8'h04;
        clear_stats();
        exp_dev.push_back(8'h01); exp_dev.push_back(8'h02);
        err_en = 1; err_addr = 11'h502;
        pulse_start(32'h400);
        wait_idle("R8");
        err_en = 0;
        chk("R8 flags", {busy, done, err, irq}, 4'b0011);
        chk("R8 remaining count", rem_count, 2);
        chk("R8 descriptor kept", cur_desc, 32'h400);
        chk("R8 bytes before error", exp_dev.size(), 0);
        pulse_clear();
        chk("R10 error cleared", {err, irq}, 0);

        // R9: device error on the second device handshake
        put_desc(32'h440, 1, 32'h520, 3, 0);
        clear_stats();
        exp_mem.push_back({11'h520, 8'hA0});
        dev_err_en = 1; dev_err_idx = 1;
        pulse_start(32'h440);
        wait_idle("R9");
        dev_err_en = 0;
        chk("R9 flags", {busy, done, err, irq}, 4'b0011);
        chk("R9 remaining count", rem_count, 2);
        chk("R9 descriptor kept", cur_desc, 32'h440);
        chk("R9 memory writes", exp_mem.size(), 0);
        pulse_clear();

        // R8: bus error while fetching the second descriptor
        put_desc(32'h480, 0, 32'h540, 1, 32'h4C0);
        put_desc(32'h4C0, 0, 32'h560, 1, 0);
        mem[11'h540] = 8'h5A;
        clear_stats();
        exp_dev.push_back(8'h5A);
        err_en = 1; err_addr = 11'h4C8;
        pulse_start(32'h480);
        wait_idle("R8 fetch");
        err_en = 0;
        chk("R8 fetch error flags", {done, err}, 2'b01);
        chk("R8 fetch error descriptor", cur_desc, 32'h4C0);
        chk("R8 fetch error bytes", exp_dev.size(), 0);
        chk("R12 no pending requests", {bus_req, dev_req}, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule